// File: doc/BRIEF.md
# Directional Three-Step Motion Search Controller

This controller sequences a reduced three-step block-matching search for one 16x16 current block over a window of ±7 pixels in each axis. It does not compute costs itself. It issues batches of up to three candidate displacements to an external matching-cost engine. The engine returns one MAD value per candidate with a single strobe. The controller keeps the running minimum and reports the final motion vector, together with the number of candidate points that were evaluated.

The search direction comes from the signed motion vector of the block to the left, sampled with the start strobe. Each step has two phases:
- The first phase tests three points: the current centre, the point one step away horizontally towards the predicted side, and the point one step away vertically towards the predicted side.
- The second phase tests one or two points, depending on which first-phase point won.

The step sizes are 4, 2 and 1 pixels. The winner of each step becomes the centre of the next step.

Top module: `dts_ctrl`

## Requirements
- R1: After reset, `cand_vld_o` is 0, `done_o` is 0, the motion vector outputs are 0 and `pts_o` is 0.
- R2: Step size is 4, 2, 1 for steps 1, 2, 3. Direction signs are taken from `nb_mv_x_i`/`nb_mv_y_i` (two's complement, 4 bits) at start. A negative component gives direction -1. Zero or positive gives +1. A first-phase batch puts these points in the slots: slot 0 = centre (cx,cy), slot 1 = (cx+sx*S, cy), slot 2 = (cx, cy+sy*S). The first step's centre is (0,0).
- R3: A second-phase batch depends on the first-phase winner.
  - Horizontal point won: slot 0 = (cx+2*sx*S, cy).
  - Vertical point won: slot 0 = (cx, cy+2*sy*S).
  - Centre won: slot 0 is unused.
  - In every case, slot 1 = diagonal (cx+sx*S, cy+sy*S), and slot 2 is never valid.
- R4: A candidate with either component outside ±7 has its `cand_vld_o` bit low and is not counted. A batch with no valid candidate is not issued.
- R5: The lowest cost wins. On equal costs, the lower slot wins. In the second phase, the first-phase winner keeps its place on a tie.
- R6: The winner of a step is the centre of the next step. The winner of the third step is output on `mv_x_o`/`mv_y_o` (two's complement).
- R7: Costs are accepted only while a batch is outstanding. A `cost_vld_i` pulse while idle has no effect.
- R8: `pts_o` equals the number of valid candidates issued for the block. It lies between 12 and 15.
- R9: `done_o` is a one-cycle pulse. It rises in the second cycle after the edge that samples the final `cost_vld_i`. The results hold until the next completed search.
- R10: Each batch is shown on `cand_vld_o` for exactly one cycle. The next batch appears in the second cycle after the edge that samples the costs. The first batch appears in the cycle after `start_i` is sampled.
- R11: `start_i` while a search is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a search when idle |
| nb_mv_x_i | input | 4 | Left neighbour vector, horizontal, signed |
| nb_mv_y_i | input | 4 | Left neighbour vector, vertical, signed |
| cand_vld_o | output | 3 | Per-slot candidate valid, one-cycle batch strobe |
| cand_dx_o | output | 12 | Slot horizontal displacements, 4 bits signed each, slot 0 in bits 3:0 |
| cand_dy_o | output | 12 | Slot vertical displacements, same packing |
| cost_vld_i | input | 1 | Costs for the outstanding batch are valid |
| cost_i | input | 48 | Slot costs, 16 bits each, slot 0 in bits 15:0 |
| done_o | output | 1 | Search finished, one cycle |
| mv_x_o | output | 4 | Final horizontal vector, signed |
| mv_y_o | output | 4 | Final vertical vector, signed |
| pts_o | output | 4 | Number of points checked |

## Verification
The bench models the cost engine with a 256-cycle return latency. It counts cycles at falling edges and checks the timing of each result:
- The cost strobe is sampled at edge e.
- The next batch is expected two cycles later.
- `done_o` is also expected two cycles later, with the vector and count read in that same cycle.

Batch contents are logged at the falling edge of the single issue cycle and compared against slot positions worked out by hand. Final vectors are also compared against a behavioural model of the step rules.

// File: rtl/dts_pkg.sv
package dts_pkg;
  localparam int N_SLOT  = 3;
  localparam int N_STEPS = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_ADV,
    ST_DONE
  } state_e;

  typedef enum logic [1:0] {
    WIN_C,
    WIN_H,
    WIN_V
  } win_e;
endpackage

// File: rtl/dts_cand_gen.sv
module dts_cand_gen
  import dts_pkg::*;
#(
  parameter int RANGE = 7,
  parameter int MV_W  = 4
) (
  input  logic signed [MV_W-1:0]        cen_x_i,
  input  logic signed [MV_W-1:0]        cen_y_i,
  input  logic        [MV_W-1:0]        size_i,
  input  logic                          phase_i,
  input  win_e                          win_i,
  input  logic                          neg_x_i,
  input  logic                          neg_y_i,
  output logic        [N_SLOT*MV_W-1:0] dx_o,
  output logic        [N_SLOT*MV_W-1:0] dy_o,
  output logic        [N_SLOT-1:0]      vld_o
);
  localparam int EW = MV_W + 2;
  localparam logic signed [EW-1:0] LIM = EW'(RANGE);

  logic signed [EW-1:0] cx, cy, sx, sy, sz;
  logic signed [EW-1:0] px [N_SLOT];
  logic signed [EW-1:0] py [N_SLOT];
  logic [N_SLOT-1:0]    want;

  always_comb begin
    cx = EW'(cen_x_i);
    cy = EW'(cen_y_i);
    sz = $signed(EW'(size_i));
    sx = neg_x_i ? -sz : sz;
    sy = neg_y_i ? -sz : sz;
    for (int i = 0; i < N_SLOT; i++) begin
      px[i] = '0;
      py[i] = '0;
    end
    want = '0;
    if (!phase_i) begin
      px[0] = cx;      py[0] = cy;
      px[1] = cx + sx; py[1] = cy;
      px[2] = cx;      py[2] = cy + sy;
      want  = '1;
    end else begin
      // diagonal toward predicted quadrant always follows
      px[1]   = cx + sx;
      py[1]   = cy + sy;
      want[1] = 1'b1;
      unique case (win_i)
        WIN_H: begin px[0] = cx + sx + sx; py[0] = cy; want[0] = 1'b1; end
        WIN_V: begin px[0] = cx; py[0] = cy + sy + sy; want[0] = 1'b1; end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    assign vld_o[g] = want[g] && (px[g] <= LIM) && (px[g] >= -LIM)
                               && (py[g] <= LIM) && (py[g] >= -LIM);
    assign dx_o[g*MV_W +: MV_W] = px[g][MV_W-1:0];
    assign dy_o[g*MV_W +: MV_W] = py[g][MV_W-1:0];
  end
endmodule

// File: rtl/dts_min_sel.sv
module dts_min_sel
  import dts_pkg::*;
#(
  parameter int COST_W = 16,
  parameter int MV_W   = 4
) (
  input  logic                     keep_i,
  input  logic [COST_W-1:0]        inc_cost_i,
  input  logic [MV_W-1:0]          inc_x_i,
  input  logic [MV_W-1:0]          inc_y_i,
  input  logic [N_SLOT*COST_W-1:0] cost_i,
  input  logic [N_SLOT*MV_W-1:0]   dx_i,
  input  logic [N_SLOT*MV_W-1:0]   dy_i,
  input  logic [N_SLOT-1:0]        vld_i,
  output logic [COST_W-1:0]        cost_o,
  output logic [MV_W-1:0]          x_o,
  output logic [MV_W-1:0]          y_o,
  output logic [1:0]               idx_o
);
  logic              found;
  logic [COST_W-1:0] c;
  logic [MV_W-1:0]   x, y;
  logic [1:0]        idx;

  always_comb begin
    found = keep_i;
    c     = inc_cost_i;
    x     = inc_x_i;
    y     = inc_y_i;
    idx   = 2'd3;
    // strict compare: earlier slot / incumbent wins ties
    for (int i = 0; i < N_SLOT; i++) begin
      if (vld_i[i] && (!found || cost_i[i*COST_W +: COST_W] < c)) begin
        found = 1'b1;
        c     = cost_i[i*COST_W +: COST_W];
        x     = dx_i[i*MV_W +: MV_W];
        y     = dy_i[i*MV_W +: MV_W];
        idx   = 2'(i);
      end
    end
    cost_o = c;
    x_o    = x;
    y_o    = y;
    idx_o  = idx;
  end
endmodule

// File: rtl/dts_ctrl.sv
module dts_ctrl
  import dts_pkg::*;
#(
  parameter  int RANGE  = 7,
  parameter  int COST_W = 16,
  localparam int MV_W   = $clog2(RANGE + 1) + 1,
  localparam int PTS_W  = $clog2(N_STEPS * 5 + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [MV_W-1:0]          nb_mv_x_i,
  input  logic [MV_W-1:0]          nb_mv_y_i,
  output logic [N_SLOT-1:0]        cand_vld_o,
  output logic [N_SLOT*MV_W-1:0]   cand_dx_o,
  output logic [N_SLOT*MV_W-1:0]   cand_dy_o,
  input  logic                     cost_vld_i,
  input  logic [N_SLOT*COST_W-1:0] cost_i,
  output logic                     done_o,
  output logic [MV_W-1:0]          mv_x_o,
  output logic [MV_W-1:0]          mv_y_o,
  output logic [PTS_W-1:0]         pts_o
);
  localparam int SZ0 = 1 << (N_STEPS - 1);

  state_e            state_q;
  logic [1:0]        step_q;
  logic              phase_q;
  logic              neg_x_q, neg_y_q;
  logic [MV_W-1:0]   cen_x_q, cen_y_q;
  logic [MV_W-1:0]   best_x_q, best_y_q;
  logic [COST_W-1:0] best_cost_q;
  win_e              win_q;
  logic [PTS_W-1:0]  pts_q, pts_out_q;
  logic [MV_W-1:0]   mv_x_q, mv_y_q;

  logic [MV_W-1:0]        size;
  logic [N_SLOT-1:0]      gen_vld;
  logic [N_SLOT*MV_W-1:0] gen_dx, gen_dy;
  logic [COST_W-1:0]      sel_cost;
  logic [MV_W-1:0]        sel_x, sel_y;
  logic [1:0]             sel_idx;

  assign size = MV_W'(SZ0 >> step_q);

  dts_cand_gen #(.RANGE(RANGE), .MV_W(MV_W)) gen_i (
    .cen_x_i (cen_x_q),
    .cen_y_i (cen_y_q),
    .size_i  (size),
    .phase_i (phase_q),
    .win_i   (win_q),
    .neg_x_i (neg_x_q),
    .neg_y_i (neg_y_q),
    .dx_o    (gen_dx),
    .dy_o    (gen_dy),
    .vld_o   (gen_vld)
  );

  dts_min_sel #(.COST_W(COST_W), .MV_W(MV_W)) sel_i (
    .keep_i     (phase_q),
    .inc_cost_i (best_cost_q),
    .inc_x_i    (best_x_q),
    .inc_y_i    (best_y_q),
    .cost_i     (cost_i),
    .dx_i       (gen_dx),
    .dy_i       (gen_dy),
    .vld_i      (gen_vld),
    .cost_o     (sel_cost),
    .x_o        (sel_x),
    .y_o        (sel_y),
    .idx_o      (sel_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      step_q      <= '0;
      phase_q     <= 1'b0;
      neg_x_q     <= 1'b0;
      neg_y_q     <= 1'b0;
      cen_x_q     <= '0;
      cen_y_q     <= '0;
      best_x_q    <= '0;
      best_y_q    <= '0;
      best_cost_q <= '0;
      win_q       <= WIN_C;
      pts_q       <= '0;
      pts_out_q   <= '0;
      mv_x_q      <= '0;
      mv_y_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          neg_x_q <= nb_mv_x_i[MV_W-1];
          neg_y_q <= nb_mv_y_i[MV_W-1];
          cen_x_q <= '0;
          cen_y_q <= '0;
          step_q  <= '0;
          phase_q <= 1'b0;
          pts_q   <= '0;
          state_q <= ST_ISSUE;
        end
        ST_ISSUE: begin
          if (|gen_vld) begin
            pts_q   <= pts_q + PTS_W'($countones(gen_vld));
            state_q <= ST_WAIT;
          end else begin
            state_q <= ST_ADV;
          end
        end
        ST_WAIT: if (cost_vld_i) begin
          best_cost_q <= sel_cost;
          best_x_q    <= sel_x;
          best_y_q    <= sel_y;
          if (!phase_q) begin
            unique case (sel_idx)
              2'd1:    win_q <= WIN_H;
              2'd2:    win_q <= WIN_V;
              default: win_q <= WIN_C;
            endcase
          end
          state_q <= ST_ADV;
        end
        ST_ADV: begin
          if (!phase_q) begin
            phase_q <= 1'b1;
            state_q <= ST_ISSUE;
          end else if (step_q == 2'(N_STEPS - 1)) begin
            mv_x_q    <= best_x_q;
            mv_y_q    <= best_y_q;
            pts_out_q <= pts_q;
            state_q   <= ST_DONE;
          end else begin
            step_q  <= step_q + 2'd1;
            phase_q <= 1'b0;
            cen_x_q <= best_x_q;
            cen_y_q <= best_y_q;
            state_q <= ST_ISSUE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cand_vld_o = (state_q == ST_ISSUE) ? gen_vld : '0;
  assign cand_dx_o  = gen_dx;
  assign cand_dy_o  = gen_dy;
  assign done_o     = (state_q == ST_DONE);
  assign mv_x_o     = mv_x_q;
  assign mv_y_o     = mv_y_q;
  assign pts_o      = pts_out_q;
endmodule

// File: rtl/dts_ctrl_chk.sv
module dts_ctrl_chk #(
  parameter int RANGE = 7,
  parameter int MV_W  = 4,
  parameter int PTS_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        cand_vld_o,
  input logic [3*MV_W-1:0] cand_dx_o,
  input logic [3*MV_W-1:0] cand_dy_o,
  input logic              done_o,
  input logic [MV_W-1:0]   mv_x_o,
  input logic [MV_W-1:0]   mv_y_o,
  input logic [PTS_W-1:0]  pts_o
);
  localparam logic signed [MV_W-1:0] LIM = MV_W'(RANGE);

  AST_ISSUE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_vld_o != 3'b0) |=> (cand_vld_o == 3'b0)); // R10

  AST_NO_ISSUE_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cand_vld_o == 3'b0)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9

  AST_PTS_BOUNDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pts_o >= PTS_W'(12) && pts_o <= PTS_W'(15))); // R8

  AST_MV_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(mv_x_o) && $stable(mv_y_o)) |-> done_o); // R9

  AST_MV_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($signed(mv_x_o) <= LIM && $signed(mv_x_o) >= -LIM &&
                $signed(mv_y_o) <= LIM && $signed(mv_y_o) >= -LIM)); // R6

  for (genvar g = 0; g < 3; g++) begin : g_win
    AST_CAND_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cand_vld_o[g] |-> ($signed(cand_dx_o[g*MV_W +: MV_W]) >= -LIM &&
                         $signed(cand_dy_o[g*MV_W +: MV_W]) >= -LIM)); // R4
  end

  AST_SLOT2_FIRST_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_vld_o[2] |-> cand_vld_o[0]); // R3
endmodule

bind dts_ctrl dts_ctrl_chk #(.RANGE(RANGE), .MV_W(MV_W), .PTS_W(PTS_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cand_vld_o (cand_vld_o),
  .cand_dx_o  (cand_dx_o),
  .cand_dy_o  (cand_dy_o),
  .done_o     (done_o),
  .mv_x_o     (mv_x_o),
  .mv_y_o     (mv_y_o),
  .pts_o      (pts_o)
);

// File: tb/dts_ctrl_tb_top.sv
`timescale 1ns/1ps
module dts_ctrl_tb_top;
  localparam int COST_W = 16;
  localparam int LAT    = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  nb_x = '0, nb_y = '0;
  logic [2:0]  cand_vld;
  logic [11:0] cand_dx, cand_dy;
  logic        eng_vld = 1'b0, stray_vld = 1'b0;
  logic        cost_vld;
  logic [47:0] cost_r = '0;
  logic        done;
  logic [3:0]  mv_x, mv_y, pts;

  assign cost_vld = eng_vld | stray_vld;

  always #2.5 clk = ~clk;

  dts_ctrl dut_i (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start),
    .nb_mv_x_i (nb_x), .nb_mv_y_i (nb_y),
    .cand_vld_o (cand_vld), .cand_dx_o (cand_dx), .cand_dy_o (cand_dy),
    .cost_vld_i (cost_vld), .cost_i (cost_r),
    .done_o (done), .mv_x_o (mv_x), .mv_y_o (mv_y), .pts_o (pts)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // engine model and issue log
  int tx = 0, ty = 0;
  bit flat = 0;
  int cnt = 0, n_batch = 0, issued = 0, n_done = 0;
  logic [2:0] log_vld [8];
  int log_dx [8][3];
  int log_dy [8][3];
  int iss_cyc [8];
  int cost_cyc [8];

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int cost_at(int x, int y);
    return flat ? 500 : 100 * (iabs(x - tx) + iabs(y - ty));
  endfunction

  always @(negedge clk) begin
    eng_vld = 1'b0;
    if (done) n_done++;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        eng_vld = 1'b1;
        if (n_batch > 0 && n_batch <= 8) cost_cyc[n_batch-1] = cyc;
      end
    end
    if (cand_vld != 3'b0) begin
      for (int i = 0; i < 3; i++) begin
        int x, y;
        x = $signed(cand_dx[i*4 +: 4]);
        y = $signed(cand_dy[i*4 +: 4]);
        if (n_batch < 8) begin
          log_dx[n_batch][i] = x;
          log_dy[n_batch][i] = y;
        end
        cost_r[i*16 +: 16] = cand_vld[i] ? 16'(cost_at(x, y)) : 16'd0;
      end
      if (n_batch < 8) begin
        log_vld[n_batch] = cand_vld;
        iss_cyc[n_batch] = cyc;
      end
      issued += $countones(cand_vld);
      n_batch++;
      cnt = LAT - 1;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural model of the step rules
  function automatic bit inwin(int x, int y);
    return x >= -7 && x <= 7 && y >= -7 && y <= 7;
  endfunction

  task automatic ref_search(int nx, int ny, output int mx, output int my, output int np);
    int sx, sy, cx, cy, bx, by, bc, win;
    sx = (nx < 0) ? -1 : 1;
    sy = (ny < 0) ? -1 : 1;
    cx = 0; cy = 0; np = 0;
    for (int s = 0; s < 3; s++) begin
      int sz;
      int px [5];
      int py [5];
      sz = 4 >> s;
      px[0] = cx;           py[0] = cy;
      px[1] = cx + sx*sz;   py[1] = cy;
      px[2] = cx;           py[2] = cy + sy*sz;
      bc = -1; bx = cx; by = cy; win = 0;
      for (int k = 0; k < 3; k++) begin
        if (inwin(px[k], py[k])) begin
          np++;
          if (bc < 0 || cost_at(px[k], py[k]) < bc) begin
            bc = cost_at(px[k], py[k]); bx = px[k]; by = py[k]; win = k;
          end
        end
      end
      px[3] = (win == 1) ? cx + 2*sx*sz : cx;
      py[3] = (win == 2) ? cy + 2*sy*sz : cy;
      px[4] = cx + sx*sz; py[4] = cy + sy*sz;
      for (int k = 3; k < 5; k++) begin
        if ((k == 4 || win != 0) && inwin(px[k], py[k])) begin
          np++;
          if (cost_at(px[k], py[k]) < bc) begin
            bc = cost_at(px[k], py[k]); bx = px[k]; by = py[k];
          end
        end
      end
      cx = bx; cy = by;
    end
    mx = cx; my = cy;
  endtask

  task automatic run(int nx, int ny, output int mx, output int my, output int np,
                     output int dcyc);
    @(negedge clk);
    n_batch = 0; issued = 0; n_done = 0;
    nb_x = 4'(nx); nb_y = 4'(ny); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dcyc = -1;
    for (int i = 0; i < 4000; i++) begin
      if (done) begin dcyc = cyc; break; end
      @(negedge clk);
    end
    mx = $signed(mv_x); my = $signed(mv_y); np = pts;
    @(negedge clk);
    chk(done == 1'b0, "R9", "done width", done, 0);
  endtask

  task automatic compare_ref(string tag, int nx, int ny);
    int mx, my, np, dc, ex, ey, ep;
    run(nx, ny, mx, my, np, dc);
    ref_search(nx, ny, ex, ey, ep);
    chk(mx == ex && my == ey, "R6", {tag, " vector x*16+y"}, mx*16+my, ex*16+ey);
    chk(np == ep, "R8", {tag, " points"}, np, ep);
    chk(issued == np, "R8", {tag, " issued vs reported"}, issued, np);
  endtask

  task automatic t_reset();
    chk(cand_vld == 3'b0, "R1", "reset cand_vld", cand_vld, 0);
    chk(done == 1'b0, "R1", "reset done", done, 0);
    chk(mv_x == 4'd0 && mv_y == 4'd0, "R1", "reset vector", {mv_x, mv_y}, 0);
    chk(pts == 4'd0, "R1", "reset pts", pts, 0);
  endtask

  // prev (0,-2): zero treated positive; target (3,-5)
  task automatic t_first_batch();
    int mx, my, np, dc;
    tx = 3; ty = -5; flat = 0;
    run(0, -2, mx, my, np, dc);
    chk(log_vld[0] == 3'b111, "R2", "batch0 valid", log_vld[0], 7);
    chk(log_dx[0][0] == 0 && log_dy[0][0] == 0, "R2", "batch0 slot0", log_dx[0][0]*16+log_dy[0][0], 0);
    chk(log_dx[0][1] == 4 && log_dy[0][1] == 0, "R2", "batch0 slot1 x", log_dx[0][1], 4);
    chk(log_dx[0][2] == 0 && log_dy[0][2] == -4, "R2", "batch0 slot2 y", log_dy[0][2], -4);
    // step1 V wins, diag (4,-4) best -> step2 centred there with size 2
    chk(log_dx[2][0] == 4 && log_dy[2][0] == -4, "R6", "step2 centre y", log_dy[2][0], -4);
    chk(log_dx[2][1] == 6 && log_dy[2][2] == -6, "R2", "step2 slot1 x", log_dx[2][1], 6);
    chk(log_vld[1] == 3'b010, "R4", "batch1 valid (axis skipped)", log_vld[1], 2);
  endtask

  // prev (0,0), target (5,3): expect (5,4), 13 points; tie at step2
  task automatic t_hand_tie();
    int mx, my, np, dc;
    tx = 5; ty = 3; flat = 0;
    run(0, 0, mx, my, np, dc);
    chk(mx == 5, "R5", "vector x", mx, 5);
    chk(my == 4, "R5", "vector y", my, 4);
    chk(np == 13, "R8", "points", np, 13);
    chk(log_vld[1] == 3'b010, "R4", "step1 phase2 valid", log_vld[1], 2);
    chk(log_vld[3] == 3'b010, "R3", "step2 centre-won phase2 valid", log_vld[3], 2);
    chk(log_dx[3][1] == 6 && log_dy[3][1] == 6, "R3", "step2 diag x", log_dx[3][1], 6);
  endtask

  // prev (-3,-1), target (-7,-7): expect (-7,-7), 12 points
  task automatic t_hand_neg();
    int mx, my, np, dc;
    tx = -7; ty = -7; flat = 0;
    run(-3, -1, mx, my, np, dc);
    chk(mx == -7 && my == -7, "R6", "neg corner vector x", mx, -7);
    chk(np == 12, "R8", "neg corner points", np, 12);
    chk(log_dx[0][1] == -4 && log_dy[0][2] == -4, "R2", "neg batch0 dir", log_dx[0][1], -4);
  endtask

  // vertical win in step3 with axis extension in window: (0,5), 13 points
  task automatic t_vert_ext();
    int mx, my, np, dc;
    tx = 0; ty = 5; flat = 0;
    run(1, 1, mx, my, np, dc);
    chk(mx == 0 && my == 5, "R6", "vert vector y", my, 5);
    chk(np == 13, "R8", "vert points", np, 13);
    chk(log_vld[5] == 3'b011, "R3", "step3 phase2 valid", log_vld[5], 3);
    chk(log_dx[5][0] == 0 && log_dy[5][0] == 6, "R3", "step3 axis ext y", log_dy[5][0], 6);
    chk(log_dx[5][1] == 1 && log_dy[5][1] == 5, "R3", "step3 diag x", log_dx[5][1], 1);
  endtask

  // all costs equal: centre keeps winning, 12 points
  task automatic t_flat();
    int mx, my, np, dc;
    flat = 1;
    run(2, -3, mx, my, np, dc);
    chk(mx == 0 && my == 0, "R5", "flat vector x*16+y", mx*16+my, 0);
    chk(np == 12, "R5", "flat points", np, 12);
    flat = 0;
  endtask

  task automatic t_timing();
    int mx, my, np, dc;
    tx = -2; ty = 6; flat = 0;
    run(-1, 5, mx, my, np, dc);
    chk(n_batch == 6, "R10", "batch count", n_batch, 6);
    for (int b = 1; b < 6; b++)
      chk(iss_cyc[b] - cost_cyc[b-1] == 2, "R10", "issue after cost", iss_cyc[b] - cost_cyc[b-1], 2);
    chk(dc - cost_cyc[5] == 2, "R9", "done after last cost", dc - cost_cyc[5], 2);
    chk(n_done == 1, "R9", "done count", n_done, 1);
  endtask

  task automatic t_stray_idle();
    @(negedge clk);
    cost_r = '0;
    stray_vld = 1'b1;
    @(negedge clk);
    stray_vld = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(cand_vld == 3'b0 && done == 1'b0, "R7", "idle after stray cost", {cand_vld, done}, 0);
      @(negedge clk);
    end
    tx = 6; ty = -1;
    compare_ref("R7 after stray", 3, -6);
  endtask

  task automatic t_start_busy();
    int mx, my, ex, ey, ep;
    tx = -5; ty = 2; flat = 0;
    @(negedge clk);
    n_batch = 0; issued = 0; n_done = 0;
    nb_x = 4'(-2); nb_y = 4'(3); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (300) @(negedge clk);
    nb_x = 4'(5); nb_y = 4'(-5); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4000 && !done; i++) @(negedge clk);
    mx = $signed(mv_x); my = $signed(mv_y);
    ref_search(-2, 3, ex, ey, ep);
    chk(mx == ex && my == ey, "R11", "vector after busy start", mx*16+my, ex*16+ey);
    chk(pts == 4'(ep), "R11", "points after busy start", pts, ep);
    repeat (600) @(negedge clk);
    chk(n_done == 1 && n_batch == 6, "R11", "single search run", n_done*10+n_batch, 16);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_first_batch();
    t_hand_tie();
    t_hand_neg();
    t_vert_ext();
    t_flat();
    t_timing();
    t_stray_idle();
    t_start_busy();
    tx = 7;  ty = 7;  compare_ref("rnd0", 4, 2);
    tx = -3; ty = 6;  compare_ref("rnd1", -1, 7);
    tx = 2;  ty = -7; compare_ref("rnd2", -4, -4);
    tx = -6; ty = 1;  compare_ref("rnd3", 6, -2);
    tx = 1;  ty = -2; compare_ref("rnd4", -8, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule